// File: doc/BRIEF.md
# Epoch Hit Frame Builder

This block collects hit words coming from the channels of one time-to-digital converter and groups them into frames, one frame per epoch. An epoch is the interval between two pulses of the epoch strobe coming from the clock distribution. In the deployed setting that interval is 500 coarse-clock periods of 1 µs each. Each hit carries a coarse time stamp that counts within the epoch. When an epoch closes, the hits stored for it are sent out in ascending time-stamp order. The frame starts with a header word that holds the converter identifier and a running epoch number. It ends with a trailer word that holds the stored hit count and an overflow flag.

Two storage banks alternate. One bank fills with the current epoch while the other drains the epoch that has just closed. Hits are filed on arrival into per-time-stamp linked lists, so the drain only has to walk the time stamps in order. The output is a word stream with start-of-frame and end-of-frame markers. It feeds the serializer of an uplink.

Top module: `epoch_frame_builder`

## Requirements
- R1: After reset, `out_valid`, `out_sof` and `out_eof` are low until an epoch strobe arrives. The epoch open at reset is numbered 0.
- R2: The edge that samples `epoch_strobe` closes the current epoch. On the second rising edge after it, a header word appears with `out_sof`=1 and bits [SRC_W+EPN_W-1:0] = {tdc_id, epoch number}, upper bits zero. The epoch number rises by one per frame, modulo 2^EPN_W.
- R3: Between header and trailer, each stored hit is sent as {channel, coarse, fine, tot}, with tot in the least significant bits. The order is ascending coarse time stamp, and hits with equal time stamps keep their arrival order.
- R4: The frame ends with a trailer word with `out_eof`=1 and bits [CNT_W:0] = {overflow flag, stored hit count}, upper bits zero.
- R5: Once DEPTH hits of an epoch are stored, further in-range hits of that epoch are dropped. The first DEPTH arrivals are kept, the count reads DEPTH and the overflow flag is 1.
- R6: A hit whose coarse stamp is not below EPOCH_LEN is discarded. It is neither sent nor counted, and it does not set the overflow flag.
- R7: A hit presented in the same cycle as the epoch strobe belongs to the new epoch.
- R8: An epoch with no stored hits still yields a frame: the header followed by a trailer with count 0 and flag 0.
- R9: Hits that arrive while the previous frame drains are kept for the next frame. Every closed epoch yields exactly one frame, provided epochs are longer than EPOCH_LEN+DEPTH+3 cycles.
- R10: `out_sof` and `out_eof` are only high together with `out_valid`, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| epoch_strobe | input | 1 | One-cycle pulse that closes the current epoch |
| tdc_id | input | SRC_W | Converter identifier placed in each header |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_ch | input | CH_W | Channel number of the hit |
| hit_ts | input | $clog2(EPOCH_LEN) | Coarse time stamp within the epoch |
| hit_fine | input | FINE_W | Fine time of the hit |
| hit_tot | input | TOT_W | Time over threshold of the hit |
| out_valid | output | 1 | Output word is valid |
| out_word | output | CH_W+TS_W+FINE_W+TOT_W | Header, hit or trailer word |
| out_sof | output | 1 | Marks the header word |
| out_eof | output | 1 | Marks the trailer word |

## Verification
The bench uses a small configuration: six time stamps, five storage slots, and a power-of-two stamp field so that two stamp values are out of range. It targets ties between equal stamps, where an unstable walk would swap arrival order. It drives hits in the strobe cycle; a design that filed them in the closing bank would move a hit one frame early. It overflows with out-of-range hits mixed in; a design that counted those would raise the flag or the count too soon. It also sends empty epochs and enough frames to wrap the epoch number. An ordering fault shows up as a word mismatch against the bench's own sorted model, and a bank-swap fault shows up as a missing or shifted frame.

// File: rtl/efb_pkg.sv
package efb_pkg;
  typedef enum logic [2:0] {
    DR_IDLE,
    DR_HDR,
    DR_SCAN,
    DR_HIT,
    DR_TRL
  } drain_state_t;
endpackage

// File: rtl/efb_hit_bank.sv
// One storage bank: hit words plus one linked list per coarse time stamp.
module efb_hit_bank #(
  parameter int EPOCH_LEN = 500,
  parameter int DEPTH     = 256,
  parameter int WORD_W    = 33,
  parameter int TS_W      = 9,
  parameter int AW        = 8,
  parameter int CNT_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_epoch,
  input  logic              wr_en,
  input  logic [TS_W-1:0]   wr_ts,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [TS_W-1:0]   rd_ts,
  input  logic [AW-1:0]     rd_addr,
  input  logic              clr_en,
  input  logic [TS_W-1:0]   clr_ts,
  output logic              rd_tsval,
  output logic [AW-1:0]     rd_head,
  output logic [AW-1:0]     rd_tail,
  output logic [WORD_W-1:0] rd_word,
  output logic [AW-1:0]     rd_next,
  output logic [CNT_W-1:0]  stored_cnt,
  output logic              ovf
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WORD_W-1:0]    word_mem [DEPTH];
  logic [AW-1:0]        next_mem [DEPTH];
  logic [AW-1:0]        head_mem [EPOCH_LEN];
  logic [AW-1:0]        tail_mem [EPOCH_LEN];
  logic [EPOCH_LEN-1:0] ts_valid;
  logic [CNT_W-1:0]     cnt_q;
  logic                 ovf_q;

  logic [CNT_W-1:0] base_cnt;
  logic             base_ovf;
  logic             full;
  logic             do_wr;
  logic [AW-1:0]    wr_addr;

  assign base_cnt = open_epoch ? '0 : cnt_q;
  assign base_ovf = open_epoch ? 1'b0 : ovf_q;
  assign full     = (base_cnt == FULL_CNT);
  assign do_wr    = wr_en && !full;
  assign wr_addr  = base_cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (do_wr) begin
      word_mem[wr_addr] <= wr_word;
      if (ts_valid[wr_ts]) next_mem[tail_mem[wr_ts]] <= wr_addr;
      else                 head_mem[wr_ts] <= wr_addr;
      tail_mem[wr_ts] <= wr_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_valid <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (clr_en) ts_valid[clr_ts] <= 1'b0;
      if (do_wr)  ts_valid[wr_ts]  <= 1'b1;
      cnt_q <= base_cnt + CNT_W'(do_wr);
      ovf_q <= base_ovf | (wr_en && full);
    end
  end

  assign rd_tsval   = ts_valid[rd_ts];
  assign rd_head    = head_mem[rd_ts];
  assign rd_tail    = tail_mem[rd_ts];
  assign rd_word    = word_mem[rd_addr];
  assign rd_next    = next_mem[rd_addr];
  assign stored_cnt = cnt_q;
  assign ovf        = ovf_q;
endmodule

// File: rtl/efb_drain_seq.sv
// Walks the time stamps of the draining bank and emits header, hits, trailer.
module efb_drain_seq
  import efb_pkg::*;
#(
  parameter int EPOCH_LEN = 500,
  parameter int TS_W      = 9,
  parameter int AW        = 8,
  parameter int WORD_W    = 33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [WORD_W-1:0] hdr_word,
  input  logic [WORD_W-1:0] trl_word,
  input  logic              rd_tsval,
  input  logic [AW-1:0]     rd_head,
  input  logic [AW-1:0]     rd_tail,
  input  logic [WORD_W-1:0] rd_word,
  input  logic [AW-1:0]     rd_next,
  output logic [TS_W-1:0]   rd_ts,
  output logic [AW-1:0]     rd_addr,
  output logic              clr_en,
  output logic [TS_W-1:0]   clr_ts,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_sof,
  output logic              out_eof
);
  localparam logic [TS_W-1:0] LAST_TS = TS_W'(EPOCH_LEN - 1);

  drain_state_t    st;
  logic [TS_W-1:0] ts_q;
  logic [AW-1:0]   cur_q;
  logic            at_tail;

  assign at_tail = (cur_q == rd_tail);
  assign rd_ts   = ts_q;
  assign rd_addr = cur_q;
  assign clr_en  = (st == DR_HIT) && at_tail;
  assign clr_ts  = ts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= DR_IDLE;
      ts_q      <= '0;
      cur_q     <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      case (st)
        DR_IDLE: if (go) st <= DR_HDR;
        DR_HDR: begin
          out_valid <= 1'b1;
          out_sof   <= 1'b1;
          out_word  <= hdr_word;
          ts_q      <= '0;
          st        <= DR_SCAN;
        end
        DR_SCAN: begin
          if (rd_tsval) begin
            cur_q <= rd_head;
            st    <= DR_HIT;
          end else if (ts_q == LAST_TS) begin
            st <= DR_TRL;
          end else begin
            ts_q <= ts_q + 1'b1;
          end
        end
        DR_HIT: begin
          out_valid <= 1'b1;
          out_word  <= rd_word;
          if (at_tail) begin
            if (ts_q == LAST_TS) st <= DR_TRL;
            else begin
              ts_q <= ts_q + 1'b1;
              st   <= DR_SCAN;
            end
          end else begin
            cur_q <= rd_next;
          end
        end
        DR_TRL: begin
          out_valid <= 1'b1;
          out_eof   <= 1'b1;
          out_word  <= trl_word;
          st        <= DR_IDLE;
        end
        default: st <= DR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epoch_frame_builder.sv
module epoch_frame_builder #(
  parameter int EPOCH_LEN = 500,
  parameter int DEPTH     = 256,
  parameter int CH_W      = 5,
  parameter int FINE_W    = 11,
  parameter int TOT_W     = 8,
  parameter int SRC_W     = 8,
  parameter int EPN_W     = 16,
  localparam int TS_W     = $clog2(EPOCH_LEN),
  localparam int WORD_W   = CH_W + TS_W + FINE_W + TOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              epoch_strobe,
  input  logic [SRC_W-1:0]  tdc_id,
  input  logic              hit_valid,
  input  logic [CH_W-1:0]   hit_ch,
  input  logic [TS_W-1:0]   hit_ts,
  input  logic [FINE_W-1:0] hit_fine,
  input  logic [TOT_W-1:0]  hit_tot,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_sof,
  output logic              out_eof
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [TS_W:0] LEN_X = (TS_W + 1)'(EPOCH_LEN);

  logic             fill_sel;
  logic             next_fill;
  logic             drain_idx;
  logic [EPN_W-1:0] epoch_cnt;
  logic [EPN_W-1:0] drain_epoch;
  logic             hit_ok;
  logic [WORD_W-1:0] hit_word;

  assign hit_ok    = hit_valid && ({1'b0, hit_ts} < LEN_X);
  assign hit_word  = {hit_ch, hit_ts, hit_fine, hit_tot};
  assign next_fill = epoch_strobe ? ~fill_sel : fill_sel;
  assign drain_idx = ~fill_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_sel    <= 1'b0;
      epoch_cnt   <= '0;
      drain_epoch <= '0;
    end else if (epoch_strobe) begin
      fill_sel    <= ~fill_sel;
      drain_epoch <= epoch_cnt;
      epoch_cnt   <= epoch_cnt + 1'b1;
    end
  end

  logic [TS_W-1:0]   rd_ts, clr_ts;
  logic [AW-1:0]     rd_addr;
  logic              clr_en;
  logic              bank_tsval [2];
  logic [AW-1:0]     bank_head  [2];
  logic [AW-1:0]     bank_tail  [2];
  logic [WORD_W-1:0] bank_word  [2];
  logic [AW-1:0]     bank_next  [2];
  logic [CNT_W-1:0]  bank_cnt   [2];
  logic              bank_ovf   [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    efb_hit_bank #(
      .EPOCH_LEN(EPOCH_LEN), .DEPTH(DEPTH), .WORD_W(WORD_W),
      .TS_W(TS_W), .AW(AW), .CNT_W(CNT_W)
    ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .open_epoch (epoch_strobe && (next_fill == 1'(b))),
      .wr_en      (hit_ok && (next_fill == 1'(b))),
      .wr_ts      (hit_ts),
      .wr_word    (hit_word),
      .rd_ts      (rd_ts),
      .rd_addr    (rd_addr),
      .clr_en     (clr_en && (fill_sel != 1'(b))),
      .clr_ts     (clr_ts),
      .rd_tsval   (bank_tsval[b]),
      .rd_head    (bank_head[b]),
      .rd_tail    (bank_tail[b]),
      .rd_word    (bank_word[b]),
      .rd_next    (bank_next[b]),
      .stored_cnt (bank_cnt[b]),
      .ovf        (bank_ovf[b])
    );
  end

  logic [WORD_W-1:0] hdr_word, trl_word;
  assign hdr_word = WORD_W'({tdc_id, drain_epoch});
  assign trl_word = WORD_W'({bank_ovf[drain_idx], bank_cnt[drain_idx]});

  efb_drain_seq #(
    .EPOCH_LEN(EPOCH_LEN), .TS_W(TS_W), .AW(AW), .WORD_W(WORD_W)
  ) u_drain (
    .clk       (clk),
    .rst       (rst),
    .go        (epoch_strobe),
    .hdr_word  (hdr_word),
    .trl_word  (trl_word),
    .rd_tsval  (bank_tsval[drain_idx]),
    .rd_head   (bank_head[drain_idx]),
    .rd_tail   (bank_tail[drain_idx]),
    .rd_word   (bank_word[drain_idx]),
    .rd_next   (bank_next[drain_idx]),
    .rd_ts     (rd_ts),
    .rd_addr   (rd_addr),
    .clr_en    (clr_en),
    .clr_ts    (clr_ts),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );
endmodule

// File: rtl/efb_frame_checker.sv
module efb_frame_checker #(
  parameter int EPOCH_LEN = 500,
  parameter int DEPTH     = 256,
  parameter int CH_W      = 5,
  parameter int FINE_W    = 11,
  parameter int TOT_W     = 8,
  parameter int SRC_W     = 8,
  parameter int EPN_W     = 16,
  localparam int TS_W     = $clog2(EPOCH_LEN),
  localparam int WORD_W   = CH_W + TS_W + FINE_W + TOT_W,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              epoch_strobe,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word,
  input logic              out_sof,
  input logic              out_eof
);
  localparam int TS_LO = FINE_W + TOT_W;

  logic             seen_hdr;
  logic [EPN_W-1:0] prev_epoch;
  logic [15:0]      hit_n;
  logic [TS_W-1:0]  last_ts;
  logic             is_hit;
  logic [TS_W-1:0]  w_ts;
  logic [EPN_W-1:0] w_epoch;
  logic [CNT_W-1:0] w_cnt;
  logic             w_ovf;

  assign is_hit  = out_valid && !out_sof && !out_eof;
  assign w_ts    = out_word[TS_LO +: TS_W];
  assign w_epoch = out_word[EPN_W-1:0];
  assign w_cnt   = out_word[CNT_W-1:0];
  assign w_ovf   = out_word[CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_hdr   <= 1'b0;
      prev_epoch <= '0;
      hit_n      <= '0;
      last_ts    <= '0;
    end else if (out_valid) begin
      if (out_sof) begin
        seen_hdr   <= 1'b1;
        prev_epoch <= w_epoch;
        hit_n      <= '0;
      end else if (!out_eof) begin
        hit_n   <= hit_n + 1'b1;
        last_ts <= w_ts;
      end
    end
  end

  AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (out_sof || out_eof) |-> out_valid); // R10
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(out_sof && out_eof)); // R10
  AST_HDR_LATENCY: assert property (@(posedge clk) disable iff (rst)
    epoch_strobe |=> ##1 (out_valid && out_sof)); // R2
  AST_EPOCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_sof && seen_hdr) |-> (w_epoch == EPN_W'(prev_epoch + 1'b1))); // R2
  AST_FIRST_EPOCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_sof && !seen_hdr) |-> (w_epoch == '0)); // R1
  AST_TS_ORDER: assert property (@(posedge clk) disable iff (rst)
    (is_hit && hit_n != 0) |-> (w_ts >= last_ts)); // R3
  AST_TRL_COUNT: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> (32'(w_cnt) == 32'(hit_n))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> (32'(w_cnt) <= DEPTH)); // R5
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (rst)
    (out_eof && w_ovf) |-> (32'(w_cnt) == DEPTH)); // R5
  AST_HIT_TS_RANGE: assert property (@(posedge clk) disable iff (rst)
    is_hit |-> (32'(w_ts) < EPOCH_LEN)); // R6
endmodule

bind epoch_frame_builder efb_frame_checker #(
  .EPOCH_LEN(EPOCH_LEN), .DEPTH(DEPTH), .CH_W(CH_W), .FINE_W(FINE_W),
  .TOT_W(TOT_W), .SRC_W(SRC_W), .EPN_W(EPN_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .epoch_strobe (epoch_strobe),
  .out_valid    (out_valid),
  .out_word     (out_word),
  .out_sof      (out_sof),
  .out_eof      (out_eof)
);

// File: tb/sim_epoch_frame_builder.sv
module sim_epoch_frame_builder;
  localparam int CLK_PERIOD = 10;
  localparam int EPOCH_LEN  = 6;
  localparam int DEPTH      = 5;
  localparam int CH_W = 2, FINE_W = 3, TOT_W = 2, SRC_W = 4, EPN_W = 6;
  localparam int TS_W = 3;
  localparam int W    = CH_W + TS_W + FINE_W + TOT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic epoch_strobe = 1'b0;
  logic [SRC_W-1:0] tdc_id = 4'hA;
  logic hit_valid = 1'b0;
  logic [CH_W-1:0] hit_ch = '0;
  logic [TS_W-1:0] hit_ts = '0;
  logic [FINE_W-1:0] hit_fine = '0;
  logic [TOT_W-1:0] hit_tot = '0;
  logic out_valid, out_sof, out_eof;
  logic [W-1:0] out_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  epoch_frame_builder #(
    .EPOCH_LEN(EPOCH_LEN), .DEPTH(DEPTH), .CH_W(CH_W), .FINE_W(FINE_W),
    .TOT_W(TOT_W), .SRC_W(SRC_W), .EPN_W(EPN_W)
  ) u0 (
    .clk(clk), .rst(rst), .epoch_strobe(epoch_strobe), .tdc_id(tdc_id),
    .hit_valid(hit_valid), .hit_ch(hit_ch), .hit_ts(hit_ts),
    .hit_fine(hit_fine), .hit_tot(hit_tot), .out_valid(out_valid),
    .out_word(out_word), .out_sof(out_sof), .out_eof(out_eof)
  );

  int checks = 0;
  int errors = 0;

  // bench model of the open epoch
  logic [TS_W-1:0] m_ts [0:15];
  logic [W-1:0]    m_w  [0:15];
  int              m_n = 0;
  logic            m_ovf = 1'b0;
  logic [EPN_W-1:0] m_epoch = '0;
  logic [W+1:0]    exp_q [$];
  logic [W-1:0]    last_trl = '0;

  task automatic check(input bit ok, input string tag, input logic [W+1:0] act,
                       input logic [W+1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic close_epoch();
    exp_q.push_back({1'b1, 1'b0, W'({tdc_id, m_epoch})});
    for (int t = 0; t < EPOCH_LEN; t++)
      for (int i = 0; i < m_n; i++)
        if (int'(m_ts[i]) == t) exp_q.push_back({2'b00, m_w[i]});
    exp_q.push_back({1'b0, 1'b1, W'({m_ovf, 3'(m_n)})});
    m_epoch = m_epoch + 1'b1;
    m_n = 0;
    m_ovf = 1'b0;
  endtask

  // drive one cycle; inputs change just after a rising edge
  task automatic step(input bit s, input bit hv, input int ch, input int ts,
                      input int f, input int t);
    epoch_strobe = s;
    hit_valid = hv;
    hit_ch = CH_W'(ch);
    hit_ts = TS_W'(ts);
    hit_fine = FINE_W'(f);
    hit_tot = TOT_W'(t);
    if (s) close_epoch();              // R7: strobe-cycle hit goes to new epoch
    if (hv && ts < EPOCH_LEN) begin    // R6: out-of-range stamps ignored
      if (m_n < DEPTH) begin
        m_ts[m_n] = TS_W'(ts);
        m_w[m_n] = {CH_W'(ch), TS_W'(ts), FINE_W'(f), TOT_W'(t)};
        m_n++;
      end else m_ovf = 1'b1;           // R5
    end
    @(posedge clk);
    #1;
    epoch_strobe = 1'b0;
    hit_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  // output monitor: every word is compared with the model queue
  always @(negedge clk) begin
    if (!rst) begin
      if (!out_valid && (out_sof || out_eof))
        check(1'b0, "R10 marker without valid", {out_sof, out_eof, out_word}, '0);
      if (out_valid) begin
        string tag;
        logic [W+1:0] act, exp;
        act = {out_sof, out_eof, out_word};
        tag = out_sof ? "R2 header" : (out_eof ? "R4 trailer" : "R3 hit");
        if (exp_q.size() == 0) begin
          check(1'b0, {tag, " unexpected word"}, act, '0);
        end else begin
          exp = exp_q.pop_front();
          check(act == exp, tag, act, exp);
        end
        if (out_eof) last_trl = out_word;
      end
    end
  end

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !out_sof && !out_eof, "R1 reset outputs low",
          {out_sof, out_eof, out_word}, '0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!out_valid, "R1 idle after reset", {1'b0, 1'b0, W'(out_valid)}, '0);
    end
    @(posedge clk);
    #1;

    // empty epoch 0, header latency
    step(1, 0, 0, 0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    check(out_valid && out_sof && out_word == W'({4'hA, 6'd0}),
          "R2 header two edges after strobe, R1 epoch 0",
          {out_sof, out_eof, out_word}, {2'b10, W'({4'hA, 6'd0})});
    #1;
    idle(16);
    check(last_trl == '0, "R8 empty epoch trailer", {2'b01, last_trl}, {2'b01, W'(0)});

    // ordering with ties
    step(0, 1, 1, 4, 1, 1);
    step(0, 1, 2, 1, 2, 2);
    step(0, 1, 3, 4, 3, 3);
    step(0, 1, 0, 0, 4, 0);
    step(0, 1, 1, 2, 5, 1);
    step(1, 0, 0, 0, 0, 0);
    idle(18);
    check(last_trl == W'({1'b0, 3'd5}), "R4 trailer count 5",
          {2'b01, last_trl}, {2'b01, W'({1'b0, 3'd5})});

    // overflow with out-of-range stamps mixed in
    for (int i = 0; i < 9; i++) step(0, 1, i % 4, (i * 5) % 8, i % 8, i % 4);
    step(1, 0, 0, 0, 0, 0);
    idle(18);
    check(last_trl == W'({1'b1, 3'd5}), "R5 overflow flag and count",
          {2'b01, last_trl}, {2'b01, W'({1'b1, 3'd5})});

    // only out-of-range stamps
    step(0, 1, 1, 6, 1, 1);
    step(0, 1, 2, 7, 2, 2);
    step(1, 0, 0, 0, 0, 0);
    idle(18);
    check(last_trl == '0, "R6 out-of-range not counted", {2'b01, last_trl}, {2'b01, W'(0)});

    // hit on the strobe cycle
    step(1, 1, 3, 3, 7, 3);
    idle(18);
    check(last_trl == '0, "R7 closing frame excludes strobe hit",
          {2'b01, last_trl}, {2'b01, W'(0)});
    step(1, 0, 0, 0, 0, 0);
    idle(18);
    check(last_trl == W'({1'b0, 3'd1}), "R7 strobe hit in next frame",
          {2'b01, last_trl}, {2'b01, W'({1'b0, 3'd1})});

    // sweep, hits overlapping the previous drain, epoch number wraps
    for (int k = 0; k < 70; k++) begin
      int n;
      n = k % 8;
      for (int i = 0; i < n; i++)
        step((i == 0) && (k % 2 == 1), 1, i % 4, (i * 5 + k) % 8, (i + k) % 8, k % 4);
      if (n == 0 || k % 2 == 0) step(1, 0, 0, 0, 0, 0);
      idle(20 - n);
    end
    step(1, 0, 0, 0, 0, 0);
    idle(30);
    check(exp_q.size() == 0, "R9 every frame delivered",
          {2'b00, W'(exp_q.size())}, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule